// File: doc/BRIEF.md
# Supply Status Flag Generator with Hysteresis

This block turns two 10-bit voltage conversion results, one taken on the rectified input rail and one on the regulated output rail, into an 8-bit status byte. Each voltage flag has its own pair of thresholds: a higher one that sets it and a lower one that clears it. While the code lies between the two, the flag keeps its state, so a rail that sits close to one threshold does not make the bit chatter. The rectifier over-voltage flag also follows the state of the external clamp. It can only set while the clamp is off, and it can only clear once the clamp has been engaged. One further bit reports whether the output converter has finished its soft start.

All thresholds are given in millivolts at the rail and are turned into ADC codes at elaboration time. The conversion uses the sense-path gain of each channel as a divider times ten and a full-scale input of 1 V, and computes round(V × gain × 1023). The flags change only in a cycle where the sample-valid strobe is high. The new byte is visible after that clock edge. Unused bits always read zero.

Top module: `pwr_stat_flags`

## Requirements
- R1: After a synchronous reset, which is active high, every bit of the status byte is 0.
- R2: The status byte changes only on a clock edge where `smp_vld` is 1. The new value appears right after that edge. With `smp_vld` at 0 the byte holds whatever the inputs do.
- R3: Bit 5 (output over-voltage) sets when `out_code` > 954 (5.5 V at gain 1/5.9). It clears when `out_code` < 902 (5.2 V).
- R4: Bit 4 (rectifier over-voltage) sets only when `clamp_on` is 0 and `rect_code` > 921 (18 V at gain 1/20). It clears only when `clamp_on` is 1 and `rect_code` < 818 (16 V).
- R5: Bit 3 takes the value of `ss_done` at each valid sample: 1 once soft start is finished, 0 while it is running.
- R6: Bit 1 (rectifier in range) sets when `rect_code` > 307 (6 V). It clears when `rect_code` < 230 (4.5 V).
- R7: Bit 0 (output in range) sets when `out_code` > 780 (4.5 V). It clears when `out_code` < 728 (4.2 V).
- R8: A code equal to a threshold, or lying between the clear and set thresholds, leaves the flag unchanged. Comparisons are strict.
- R9: Bits 7, 6 and 2 always read 0.
- R10: Each threshold code equals round(mV × 1023 × 10 / (gain divider ×10 × full-scale mV)), derived from parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample-valid strobe; the codes are evaluated in this cycle |
| rect_code | input | ADC_W | Rectifier-voltage conversion code |
| out_code | input | ADC_W | Output-voltage conversion code |
| clamp_on | input | 1 | External over-voltage clamp engaged |
| ss_done | input | 1 | Output converter soft start has finished |
| status | output | 8 | Status byte: bit 5 output OVP, bit 4 rectifier OVP, bit 3 soft start done, bit 1 rectifier in range, bit 0 output in range |

## Verification
A flag register that is wrong holds that wrong value until a sample drives the code past the opposite threshold. The error therefore shows on the status byte one cycle after the offending strobe and stays until then. A threshold that is off by one code shows only when the code sits exactly at the boundary. For that reason the bench sweeps every code upward and downward on each channel, and does so under both clamp states. This exposes wrong comparisons, lost hysteresis and missing clamp qualification at the first sample where the expected and actual bytes differ.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    // Status byte layout; the bit positions are the decoded interface.
    typedef struct packed {
        logic rsv7;
        logic rsv6;
        logic out_ovp;    // bit 5
        logic rect_ovp;   // bit 4
        logic ss_fin;     // bit 3
        logic rsv2;
        logic rect_ok;    // bit 1
        logic out_ok;     // bit 0
    } status_t;

    typedef enum logic {
        CH_RECT = 1'b0,
        CH_OUT  = 1'b1
    } chan_e;

    // Hysteresis flag slots inside the generator.
    localparam int NFLAG      = 4;
    localparam int F_OUT_OK   = 0;
    localparam int F_RECT_OK  = 1;
    localparam int F_RECT_OVP = 2;
    localparam int F_OUT_OVP  = 3;

    // round(mv * maxc / (den10/10 * fs_mv)) in integer arithmetic
    function automatic int mv_to_code(input int mv, input int den_x10,
                                      input int fs_mv, input int adc_w);
        int maxc;
        int num;
        int div;
        maxc = (1 << adc_w) - 1;
        num  = mv * maxc * 10;
        div  = den_x10 * fs_mv;
        mv_to_code = (num + div / 2) / div;
    endfunction

endpackage

// File: rtl/sflag_hyst.sv
module sflag_hyst #(
    parameter int ADC_W    = 10,
    parameter int SET_CODE = 954,
    parameter int CLR_CODE = 902
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [ADC_W-1:0] code,
    input  logic             set_en,
    input  logic             clr_en,
    output logic             flag
);

    localparam logic [ADC_W-1:0] SET_V = SET_CODE[ADC_W-1:0];
    localparam logic [ADC_W-1:0] CLR_V = CLR_CODE[ADC_W-1:0];

    logic above;
    logic below;

    always_comb begin
        above = (code > SET_V) && set_en;
        below = (code < CLR_V) && clr_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (smp_vld) begin
            if (above) begin
                flag <= 1'b1;
            end else if (below) begin
                flag <= 1'b0;
            end
        end
    end

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(flag)); // R2

    AST_RISE_ABOVE_SET: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(code) > SET_V)); // R8

    AST_FALL_BELOW_CLR: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> ($past(code) < CLR_V)); // R8

endmodule

// File: rtl/sflag_capture.sv
module sflag_capture (
    input  logic clk,
    input  logic rst,
    input  logic smp_vld,
    input  logic din,
    output logic dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= 1'b0;
        end else if (smp_vld) begin
            dout <= din;
        end
    end

    AST_SS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        $past(smp_vld) && !$past(rst) |-> (dout == $past(din))); // R5

endmodule

// File: rtl/pwr_stat_flags.sv
module pwr_stat_flags
    import sflag_pkg::*;
#(
    parameter int ADC_W             = 10,
    parameter int FS_MV             = 1000,
    parameter int RECT_GAIN_DEN_X10 = 200,
    parameter int OUT_GAIN_DEN_X10  = 59,
    parameter int OUT_OVP_SET_MV    = 5500,
    parameter int OUT_OVP_CLR_MV    = 5200,
    parameter int RECT_OVP_SET_MV   = 18000,
    parameter int RECT_OVP_CLR_MV   = 16000,
    parameter int RECT_OK_SET_MV    = 6000,
    parameter int RECT_OK_CLR_MV    = 4500,
    parameter int OUT_OK_SET_MV     = 4500,
    parameter int OUT_OK_CLR_MV     = 4200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [ADC_W-1:0] rect_code,
    input  logic [ADC_W-1:0] out_code,
    input  logic             clamp_on,
    input  logic             ss_done,
    output logic [7:0]       status
);

    // R10: threshold codes derived from rail millivolts and sense gains
    localparam int SET_C [NFLAG] = '{
        mv_to_code(OUT_OK_SET_MV,   OUT_GAIN_DEN_X10,  FS_MV, ADC_W),
        mv_to_code(RECT_OK_SET_MV,  RECT_GAIN_DEN_X10, FS_MV, ADC_W),
        mv_to_code(RECT_OVP_SET_MV, RECT_GAIN_DEN_X10, FS_MV, ADC_W),
        mv_to_code(OUT_OVP_SET_MV,  OUT_GAIN_DEN_X10,  FS_MV, ADC_W)
    };
    localparam int CLR_C [NFLAG] = '{
        mv_to_code(OUT_OK_CLR_MV,   OUT_GAIN_DEN_X10,  FS_MV, ADC_W),
        mv_to_code(RECT_OK_CLR_MV,  RECT_GAIN_DEN_X10, FS_MV, ADC_W),
        mv_to_code(RECT_OVP_CLR_MV, RECT_GAIN_DEN_X10, FS_MV, ADC_W),
        mv_to_code(OUT_OVP_CLR_MV,  OUT_GAIN_DEN_X10,  FS_MV, ADC_W)
    };
    localparam chan_e CHAN [NFLAG] = '{CH_OUT, CH_RECT, CH_RECT, CH_OUT};
    localparam bit    QUAL [NFLAG] = '{1'b0, 1'b0, 1'b1, 1'b0};

    logic [NFLAG-1:0] hflag;
    logic             ss_q;
    status_t          st;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        logic [ADC_W-1:0] cin;
        logic             s_en;
        logic             c_en;

        if (CHAN[g] == CH_RECT) begin : g_rect
            assign cin = rect_code;
        end else begin : g_out
            assign cin = out_code;
        end

        if (QUAL[g]) begin : g_qual
            assign s_en = ~clamp_on;
            assign c_en = clamp_on;
        end else begin : g_free
            assign s_en = 1'b1;
            assign c_en = 1'b1;
        end

        sflag_hyst #(
            .ADC_W   (ADC_W),
            .SET_CODE(SET_C[g]),
            .CLR_CODE(CLR_C[g])
        ) u_hyst (
            .clk    (clk),
            .rst    (rst),
            .smp_vld(smp_vld),
            .code   (cin),
            .set_en (s_en),
            .clr_en (c_en),
            .flag   (hflag[g])
        );
    end

    sflag_capture u_ss (
        .clk    (clk),
        .rst    (rst),
        .smp_vld(smp_vld),
        .din    (ss_done),
        .dout   (ss_q)
    );

    always_comb begin
        st          = '0;
        st.out_ovp  = hflag[F_OUT_OVP];
        st.rect_ovp = hflag[F_RECT_OVP];
        st.ss_fin   = ss_q;
        st.rect_ok  = hflag[F_RECT_OK];
        st.out_ok   = hflag[F_OUT_OK];
    end

    assign status = st;

    AST_RECT_OVP_SET_QUAL: assert property (@(posedge clk) disable iff (rst)
        $rose(status[4]) |-> !$past(clamp_on)); // R4

    AST_RECT_OVP_CLR_QUAL: assert property (@(posedge clk) disable iff (rst)
        $fell(status[4]) |-> $past(clamp_on)); // R4

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (status == 8'h00)); // R1

    AST_STATUS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(status)); // R2

endmodule

// File: tb/tb_pwr_stat_flags.sv
module tb_pwr_stat_flags;

    logic       clk = 1'b0;
    logic       rst;
    logic       smp_vld;
    logic [9:0] rect_code;
    logic [9:0] out_code;
    logic       clamp_on;
    logic       ss_done;
    logic [7:0] status;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Threshold codes from the requirement formula, computed in real arithmetic
    int t_oovp_s, t_oovp_c, t_rovp_s, t_rovp_c;
    int t_rok_s, t_rok_c, t_ook_s, t_ook_c;

    // Reference flag state
    logic e_oovp, e_rovp, e_ss, e_rok, e_ook;

    always #2.5 clk = ~clk;

    pwr_stat_flags dut (
        .clk      (clk),
        .rst      (rst),
        .smp_vld  (smp_vld),
        .rect_code(rect_code),
        .out_code (out_code),
        .clamp_on (clamp_on),
        .ss_done  (ss_done),
        .status   (status)
    );

    function automatic int rcode(input real v, input real gain_den);
        rcode = $rtoi(v / gain_den * 1023.0 + 0.5);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s rect=%0d out=%0d clamp=%0b actual=%0b expected=%0b",
                     tag, rect_code, out_code, clamp_on, act, exp);
        end
    endtask

    task automatic chk_byte(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk(status[5], e_oovp, "R3 out ovp");
        chk(status[4], e_rovp, "R4 rect ovp");
        chk(status[3], e_ss,   "R5 soft start");
        chk(status[1], e_rok,  "R6 rect ok");
        chk(status[0], e_ook,  "R7 out ok");
        chk(status[7] | status[6] | status[2], 1'b0, "R9 reserved");
    endtask

    task automatic model(input int rc, input int oc, input logic cl, input logic ss);
        if (oc > t_oovp_s)      e_oovp = 1'b1;
        else if (oc < t_oovp_c) e_oovp = 1'b0;
        if (!cl && rc > t_rovp_s)     e_rovp = 1'b1;
        else if (cl && rc < t_rovp_c) e_rovp = 1'b0;
        e_ss = ss;
        if (rc > t_rok_s)      e_rok = 1'b1;
        else if (rc < t_rok_c) e_rok = 1'b0;
        if (oc > t_ook_s)      e_ook = 1'b1;
        else if (oc < t_ook_c) e_ook = 1'b0;
    endtask

    task automatic sample(input int rc, input int oc, input logic cl, input logic ss);
        @(negedge clk);
        rect_code = rc[9:0];
        out_code  = oc[9:0];
        clamp_on  = cl;
        ss_done   = ss;
        smp_vld   = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        model(rc, oc, cl, ss);
        check_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst     = 1'b1;
        smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        e_oovp = 0; e_rovp = 0; e_ss = 0; e_rok = 0; e_ook = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        t_oovp_s = rcode(5.5, 5.9);  t_oovp_c = rcode(5.2, 5.9);
        t_ook_s  = rcode(4.5, 5.9);  t_ook_c  = rcode(4.2, 5.9);
        t_rovp_s = rcode(18.0, 20.0); t_rovp_c = rcode(16.0, 20.0);
        t_rok_s  = rcode(6.0, 20.0);  t_rok_c  = rcode(4.5, 20.0);

        rst = 1'b1; smp_vld = 1'b0; rect_code = '0; out_code = '0;
        clamp_on = 1'b0; ss_done = 1'b0;
        do_reset();
        @(negedge clk);
        chk_byte(status, 8'h00, "R1 reset state");

        // R10: derived codes compared against the literal values in the requirements
        n_cmp++; if (t_rok_s != 307 || t_rovp_s != 921 || t_oovp_s != 954 || t_ook_c != 728) begin
            n_fail++; $display("FAIL R10 bench codes actual=%0d/%0d/%0d/%0d expected=307/921/954/728",
                               t_rok_s, t_rovp_s, t_oovp_s, t_ook_c);
        end

        // R3 R7 R8: output channel swept up then down, exhaustively
        for (int c = 0; c < 1024; c++) sample(500, c, 1'b0, c[3]);
        for (int c = 1023; c >= 0; c--) sample(500, c, 1'b0, c[4]);

        // R4 R6 R8: rectifier swept with clamp off rising, clamp on falling
        for (int c = 0; c < 1024; c++) sample(c, 800, 1'b0, 1'b1);
        for (int c = 1023; c >= 0; c--) sample(c, 800, 1'b1, 1'b0);
        // R4: opposite clamp states must neither set nor clear
        for (int c = 0; c < 1024; c++) sample(c, 800, 1'b1, c[0]);
        sample(1000, 800, 1'b0, 1'b1);
        for (int c = 1023; c >= 0; c--) sample(c, 800, 1'b0, 1'b1);
        chk(status[4], 1'b1, "R4 held with clamp off at low code");

        // R8: exact threshold codes hold the flag
        do_reset();
        sample(307, 780, 1'b0, 1'b0);
        chk(status[1], 1'b0, "R8 rect ok at set code");
        chk(status[0], 1'b0, "R8 out ok at set code");
        sample(308, 781, 1'b0, 1'b0);
        sample(230, 728, 1'b0, 1'b0);
        chk(status[1], 1'b1, "R8 rect ok at clear code");
        chk(status[0], 1'b1, "R8 out ok at clear code");

        // R2: no strobe, inputs that would change every flag
        sample(1000, 1000, 1'b0, 1'b1);
        held = status;
        @(negedge clk);
        rect_code = 10'd0; out_code = 10'd0; clamp_on = 1'b1; ss_done = 1'b0;
        repeat (6) @(negedge clk);
        chk_byte(status, held, "R2 hold without strobe");
        chk_byte(held, 8'h3B, "R2 full byte before hold");

        // R1: reset while flags set
        do_reset();
        @(negedge clk);
        chk_byte(status, 8'h00, "R1 reset after flags set");
        check_all();

        done = 1;
        summary();
        $finish;
    end

endmodule